// File: doc/BRIEF.md
# SPI NOR flash command responder

This block stands in for the device side of a serial NOR flash at the granularity of whole bytes. The bus master frames a command by driving the active-low select low and then moving one byte per transfer. For every byte it accepts, the block returns one response byte. The first byte after selection is an opcode. Depending on the opcode, the block gathers address and dummy bytes, then streams data out of a small internal byte array, merges incoming bytes into it, or sweeps a region of it back to the erased value 0xFF.

Bit-level shifting is left to a separate shifter. Multi-lane commands are handled only for the number of header bytes they take. The array size, the three erase granules, the identification code and the program mode are all parameters.

Inbound bytes use valid/ready. A byte moves when `rx_valid` and `rx_ready` are both high at a clock edge. `rx_ready` is low while the select is high and while an erase sweep runs, so the master is held off for the whole sweep. The response has no back-pressure: `tx_valid` is high for exactly the cycle after each accepted byte, and `tx_data` holds the reply in that cycle.

Top module: `spinor_responder`

## Requirements
- R1: Each accepted byte produces exactly one response, with `tx_valid` high in the following cycle. `rx_ready` is low while `cs_n` is high and while an erase sweep is in progress.
- R2: While `cs_n` is high, the command state returns to idle and the byte counters clear. The first byte after reselection is decoded as an opcode, even if the previous command was cut short.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns one status byte holding the latch in bit 1, with every other bit 0. After that byte, further bytes are decoded as opcodes.
- R4: Opcode 0x9F returns the three identification bytes, most significant first. When the extension parameter is non-zero, its two bytes follow, high byte first. The block then decodes opcodes again.
- R5: Opcodes 0x03, 0x02, 0xA2, 0x32, 0x20, 0x52 and 0xD8 take three header bytes. Opcodes 0x0B, 0x3B and 0x6B take four.
- R6: Opcode 0xBB takes four header bytes when the top identification byte is 0xEF or 0x01, and five otherwise. Opcode 0xEB takes six for those two values and eight otherwise.
- R7: The first three header bytes form the address, most significant first, reduced modulo the array size. Any later header bytes are dummies. Each byte of a read returns the array byte at the address, and the address then advances, wrapping at the array size.
- R8: Each byte of a program is ANDed into the array at the address, and the address then advances. With `OVERWRITE` set, the byte replaces the array content instead. Program bytes change nothing while the latch is clear.
- R9: Opcodes 0x20, 0x52, 0xD8 and 0xC7 set every byte of their range to 0xFF. The range is the small, medium or sector granule, or the whole array, in each case capped at the array size and starting at the address rounded down to the range size.
- R10: An erase opcode issued while the latch is clear leaves the array unchanged and starts no sweep.
- R11: Opcode 0x01 with the latch set takes one byte and then clears the latch. With the latch clear it is dropped, and the next byte is decoded as an opcode.
- R12: Any opcode not listed in R3 to R11, other than 0x00, which does nothing, makes every later byte of that selection return 0x00 and have no effect.
- R13: Reset clears the latch and `tx_valid`, then sweeps the whole array to 0xFF with `busy` high for one cycle per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low device select |
| rx_valid | input | 1 | Inbound byte present |
| rx_ready | output | 1 | Inbound byte can be taken |
| rx_data | input | 8 | Inbound byte |
| tx_valid | output | 1 | Response byte present (cycle after acceptance) |
| tx_data | output | 8 | Response byte |
| busy | output | 1 | Erase sweep in progress |

## Verification
The hardest case to reach is a header length that depends on the identification parameter. On the wire, four versus five collected bytes differ only in when the first data byte appears. The bench therefore drives two instances with identical byte streams, one built with a wide-header manufacturer code and one without. It checks that the first instance already returns array data on a byte where the second still returns 0x00. Erase alignment is reached by programming marker bytes just inside and just outside each granule before erasing from an unaligned address, and then reading the markers back.

// File: rtl/spinor_pkg.sv
package spinor_pkg;

  typedef enum logic [3:0] {
    CL_NOP, CL_WREN, CL_WRDI, CL_RDSR, CL_RDID, CL_CHIP, CL_WRSR,
    CL_READ, CL_PROG, CL_ER_SUB, CL_ER_HALF, CL_ER_SEC, CL_BAD
  } cmd_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_READ, ST_PROG, ST_REPLY, ST_MUTE
  } fsm_e;

  // Manufacturer codes that use the shorter header on the multi-lane reads
  localparam logic [7:0] MFR_SHORT_A = 8'hEF;
  localparam logic [7:0] MFR_SHORT_B = 8'h01;

endpackage

// File: rtl/spinor_decode.sv
module spinor_decode
  import spinor_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       short_hdr,
  output cmd_cls_e   cls,
  output logic [3:0] need
);

  always_comb begin
    need = 4'd3;
    unique case (opcode)
      8'h00: cls = CL_NOP;
      8'h06: cls = CL_WREN;
      8'h04: cls = CL_WRDI;
      8'h05: cls = CL_RDSR;
      8'h9F: cls = CL_RDID;
      8'hC7: cls = CL_CHIP;
      8'h01: begin cls = CL_WRSR; need = 4'd1; end
      8'h03: cls = CL_READ;
      8'h0B, 8'h3B, 8'h6B: begin cls = CL_READ; need = 4'd4; end
      8'hBB: begin cls = CL_READ; need = short_hdr ? 4'd4 : 4'd5; end
      8'hEB: begin cls = CL_READ; need = short_hdr ? 4'd6 : 4'd8; end
      8'h02, 8'hA2, 8'h32: cls = CL_PROG;
      8'h20: cls = CL_ER_SUB;
      8'h52: cls = CL_ER_HALF;
      8'hD8: cls = CL_ER_SEC;
      default: cls = CL_BAD;
    endcase
  end

endmodule

// File: rtl/spinor_store.sv
module spinor_store #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/spinor_sweep.sv
module spinor_sweep #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] last,
  output logic          busy,
  output logic [AW-1:0] waddr
);

  logic [AW-1:0] left_q;

  // Reset launches a full-array sweep so the array starts erased
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b1;
      waddr  <= '0;
      left_q <= AW'(DEPTH - 1);
    end else if (busy) begin
      if (left_q == '0) begin
        busy <= 1'b0;
      end else begin
        waddr  <= waddr + 1'b1;
        left_q <= left_q - 1'b1;
      end
    end else if (start) begin
      busy   <= 1'b1;
      waddr  <= base;
      left_q <= last;
    end
  end

endmodule

// File: rtl/spinor_responder.sv
module spinor_responder
  import spinor_pkg::*;
#(
  parameter int          MEM_BYTES    = 2048,
  parameter int          SUB_BYTES    = 4096,
  parameter int          HALF_BYTES   = 32768,
  parameter int          SECTOR_BYTES = 65536,
  parameter logic [23:0] ID_CODE      = 24'hC2A517,
  parameter logic [15:0] ID_EXT       = 16'h0000,
  parameter bit          OVERWRITE    = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       busy
);

  localparam int AW       = $clog2(MEM_BYTES);
  localparam int SUB_EFF  = (SUB_BYTES < MEM_BYTES) ? SUB_BYTES : MEM_BYTES;
  localparam int HALF_EFF = (HALF_BYTES < MEM_BYTES) ? HALF_BYTES : MEM_BYTES;
  localparam int SEC_EFF  = (SECTOR_BYTES < MEM_BYTES) ? SECTOR_BYTES : MEM_BYTES;
  localparam logic [AW-1:0] SUB_LAST  = AW'(SUB_EFF - 1);
  localparam logic [AW-1:0] HALF_LAST = AW'(HALF_EFF - 1);
  localparam logic [AW-1:0] SEC_LAST  = AW'(SEC_EFF - 1);
  localparam logic [AW-1:0] ALL_LAST  = AW'(MEM_BYTES - 1);
  localparam logic SHORT_HDR = (ID_CODE[23:16] == MFR_SHORT_A) ||
                               (ID_CODE[23:16] == MFR_SHORT_B);
  localparam logic [2:0] ID_LAST = (ID_EXT != 16'h0000) ? 3'd4 : 3'd2;

  fsm_e          state_q;
  cmd_cls_e      cls_q, dec_cls;
  logic [3:0]    need_q, dec_need, cnt_q;
  logic [23:0]   hdr_q, hdr_next;
  logic [AW-1:0] addr_q, hdr_addr;
  logic          wel_q, rstat_q;
  logic [2:0]    rpos_q;
  logic [7:0]    rdata, reply_byte, resp;
  logic          accept, hdr_done;
  logic          era_start, era_busy;
  logic [AW-1:0] era_last, era_addr;
  logic          prog_we, mem_we;
  logic [7:0]    prog_data, mem_wdata;
  logic [AW-1:0] mem_waddr;

  spinor_decode u_dec (
    .opcode(rx_data), .short_hdr(SHORT_HDR), .cls(dec_cls), .need(dec_need)
  );

  spinor_store #(.DEPTH(MEM_BYTES)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr_q), .rdata(rdata)
  );

  spinor_sweep #(.DEPTH(MEM_BYTES)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(era_start), .base(hdr_addr & ~era_last),
    .last(era_last), .busy(era_busy), .waddr(era_addr)
  );

  assign busy     = era_busy;
  assign rx_ready = !cs_n && !era_busy;
  assign accept   = rx_valid && rx_ready;
  assign hdr_next = {hdr_q[15:0], rx_data};
  assign hdr_addr = (cnt_q < 4'd3) ? hdr_next[AW-1:0] : hdr_q[AW-1:0];
  assign hdr_done = (state_q == ST_HDR) && ((cnt_q + 4'd1) == need_q);

  // Erase launch: whole-array opcode from idle, granule erases at header end
  always_comb begin
    era_start = 1'b0;
    era_last  = ALL_LAST;
    if (accept && wel_q) begin
      if (state_q == ST_IDLE && dec_cls == CL_CHIP) begin
        era_start = 1'b1;
      end else if (hdr_done) begin
        unique case (cls_q)
          CL_ER_SUB:  begin era_start = 1'b1; era_last = SUB_LAST;  end
          CL_ER_HALF: begin era_start = 1'b1; era_last = HALF_LAST; end
          CL_ER_SEC:  begin era_start = 1'b1; era_last = SEC_LAST;  end
          default: ;
        endcase
      end
    end
  end

  // Single write port: sweep and program never overlap (accept needs !busy)
  assign prog_we   = accept && (state_q == ST_PROG) && wel_q;
  assign prog_data = OVERWRITE ? rx_data : (rdata & rx_data);
  assign mem_we    = era_busy || prog_we;
  assign mem_waddr = era_busy ? era_addr : addr_q;
  assign mem_wdata = era_busy ? 8'hFF : prog_data;

  always_comb begin
    if (rstat_q) begin
      reply_byte = {6'b0, wel_q, 1'b0};
    end else begin
      unique case (rpos_q)
        3'd0:    reply_byte = ID_CODE[23:16];
        3'd1:    reply_byte = ID_CODE[15:8];
        3'd2:    reply_byte = ID_CODE[7:0];
        3'd3:    reply_byte = ID_EXT[15:8];
        default: reply_byte = ID_EXT[7:0];
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_READ:  resp = rdata;
      ST_REPLY: resp = reply_byte;
      default:  resp = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cls_q    <= CL_NOP;
      need_q   <= '0;
      cnt_q    <= '0;
      hdr_q    <= '0;
      addr_q   <= '0;
      wel_q    <= 1'b0;
      rstat_q  <= 1'b0;
      rpos_q   <= '0;
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else begin
      tx_valid <= accept;
      if (accept) tx_data <= resp;
      if (cs_n) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        rpos_q  <= '0;
      end else if (accept) begin
        unique case (state_q)
          ST_IDLE: begin
            cls_q  <= dec_cls;
            need_q <= dec_need;
            cnt_q  <= '0;
            rpos_q <= '0;
            unique case (dec_cls)
              CL_WREN: wel_q <= 1'b1;
              CL_WRDI: wel_q <= 1'b0;
              CL_RDSR: begin state_q <= ST_REPLY; rstat_q <= 1'b1; end
              CL_RDID: begin state_q <= ST_REPLY; rstat_q <= 1'b0; end
              CL_WRSR: if (wel_q) state_q <= ST_HDR;
              CL_READ, CL_PROG, CL_ER_SUB, CL_ER_HALF, CL_ER_SEC:
                state_q <= ST_HDR;
              CL_BAD:  state_q <= ST_MUTE;
              default: ;
            endcase
          end
          ST_HDR: begin
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q < 4'd3) hdr_q <= hdr_next;
            if (hdr_done) begin
              addr_q <= hdr_addr;
              unique case (cls_q)
                CL_READ: state_q <= ST_READ;
                CL_PROG: state_q <= ST_PROG;
                CL_WRSR: begin wel_q <= 1'b0; state_q <= ST_IDLE; end
                default: state_q <= ST_IDLE;
              endcase
            end
          end
          ST_READ, ST_PROG: addr_q <= addr_q + 1'b1;
          ST_REPLY: begin
            if (rpos_q == (rstat_q ? 3'd0 : ID_LAST)) state_q <= ST_IDLE;
            else rpos_q <= rpos_q + 3'd1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spinor_responder_chk.sv
module spinor_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rx_valid,
  input logic rx_ready,
  input logic tx_valid,
  input logic busy,
  input logic wel,
  input logic mem_we
);

  // R1
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> tx_valid);

  // R1
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_ready) |=> !tx_valid);

  // R2
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !tx_valid);

  // R9
  sweep_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rx_valid && rx_ready));

  // R10
  sweep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R8
  prog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !busy) |-> wel);

endmodule

bind spinor_responder spinor_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .busy(busy),
  .wel(wel_q), .mem_we(mem_we)
);

// File: tb/test_spinor_responder.sv
module test_spinor_responder;

  localparam int MEM = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rdy_a, rdy_b, tv_a, tv_b, busy_a, busy_b;
  logic [7:0] td_a, td_b;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  // Instance A: short-header manufacturer, extended ID, AND programming
  spinor_responder #(.MEM_BYTES(MEM), .SUB_BYTES(64), .HALF_BYTES(256),
    .SECTOR_BYTES(128), .ID_CODE(24'hEF3C17), .ID_EXT(16'h4D01),
    .OVERWRITE(1'b0)) i_spinor_responder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
    .rx_ready(rdy_a), .rx_data(rx_data), .tx_valid(tv_a), .tx_data(td_a),
    .busy(busy_a));

  // Instance B: long-header manufacturer, no extension, overwrite mode
  spinor_responder #(.MEM_BYTES(MEM), .SUB_BYTES(64), .HALF_BYTES(256),
    .SECTOR_BYTES(128), .ID_CODE(24'h5A6B18), .ID_EXT(16'h0000),
    .OVERWRITE(1'b1)) i_spinor_responder_b (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
    .rx_ready(rdy_b), .rx_data(rx_data), .tx_valid(tv_b), .tx_data(td_b),
    .busy(busy_b));

  // {req[31:28], pad, deselect-first[24], byte in, expect A, expect B}
  // R3 status/latch, R4 ID, R5 header lengths, R7 reads, R8 programs, R6 0xBB
  localparam int NV = 60;
  localparam logic [31:0] VEC [NV] = '{
    32'h3_1_05_00_00, 32'h3_0_FF_00_00, 32'h3_1_06_00_00, 32'h3_0_05_00_00,
    32'h3_0_00_02_02, 32'h3_0_04_00_00, 32'h3_0_05_00_00, 32'h3_0_00_00_00,
    32'h4_1_9F_00_00, 32'h4_0_00_EF_5A, 32'h4_0_00_3C_6B, 32'h4_0_00_17_18,
    32'h4_0_00_4D_00, 32'h4_0_00_01_00, 32'h4_0_05_00_00, 32'h4_0_00_00_00,
    32'h8_1_06_00_00, 32'h8_0_02_00_00, 32'h5_0_00_00_00, 32'h5_0_01_00_00,
    32'h5_0_10_00_00, 32'h8_0_A5_00_00, 32'h8_0_3C_00_00, 32'h8_1_02_00_00,
    32'h8_0_00_00_00, 32'h8_0_01_00_00, 32'h8_0_10_00_00, 32'h8_0_F0_00_00,
    32'h8_0_0F_00_00, 32'h7_1_03_00_00, 32'h7_0_00_00_00, 32'h7_0_01_00_00,
    32'h7_0_10_00_00, 32'h7_0_00_A0_F0, 32'h7_0_00_0C_0F, 32'h7_0_00_FF_FF,
    32'h8_1_04_00_00, 32'h8_0_02_00_00, 32'h8_0_00_00_00, 32'h8_0_01_00_00,
    32'h8_0_10_00_00, 32'h8_0_00_00_00, 32'h8_1_03_00_00, 32'h8_0_00_00_00,
    32'h8_0_01_00_00, 32'h8_0_10_00_00, 32'h8_0_00_A0_F0, 32'h5_1_0B_00_00,
    32'h5_0_00_00_00, 32'h5_0_01_00_00, 32'h5_0_10_00_00, 32'h5_0_77_00_00,
    32'h5_0_00_A0_F0, 32'h6_1_BB_00_00, 32'h6_0_00_00_00, 32'h6_0_01_00_00,
    32'h6_0_10_00_00, 32'h6_0_99_00_00, 32'h6_0_00_A0_00, 32'h6_0_00_0C_F0
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic xfer(input bit desel, input logic [7:0] din,
                      input logic [7:0] ea, input logic [7:0] eb,
                      input string tag);
    if (desel) begin
      @(negedge clk) cs_n = 1'b1;
      @(negedge clk);
      @(negedge clk) cs_n = 1'b0;
    end
    while (!(rdy_a && rdy_b)) @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = din;
    @(negedge clk);
    rx_valid = 1'b0;
    check(tv_a && td_a == ea, tag, "resp A", {tv_a, td_a}, {1'b1, ea});
    check(tv_b && td_b == eb, tag, "resp B", {tv_b, td_b}, {1'b1, eb});
  endtask

  task automatic rd(input logic [23:0] a, input logic [7:0] ea,
                    input logic [7:0] eb, input string tag);
    xfer(1'b1, 8'h03, 8'h00, 8'h00, tag);
    xfer(1'b0, a[23:16], 8'h00, 8'h00, tag);
    xfer(1'b0, a[15:8], 8'h00, 8'h00, tag);
    xfer(1'b0, a[7:0], 8'h00, 8'h00, tag);
    xfer(1'b0, 8'h00, ea, eb, tag);
  endtask

  task automatic prog1(input logic [23:0] a, input logic [7:0] d,
                       input string tag);
    xfer(1'b1, 8'h02, 8'h00, 8'h00, tag);
    xfer(1'b0, a[23:16], 8'h00, 8'h00, tag);
    xfer(1'b0, a[15:8], 8'h00, 8'h00, tag);
    xfer(1'b0, a[7:0], 8'h00, 8'h00, tag);
    xfer(1'b0, d, 8'h00, 8'h00, tag);
  endtask

  task automatic run_all();
    int n;
    // R13: reset state, then one sweep cycle per array byte
    repeat (3) @(negedge clk);
    check(!tv_a && busy_a, "R13", "reset tx_valid/busy", {tv_a, busy_a}, 2'b01);
    rst_n = 1'b1;
    n = 0;
    while (busy_a) begin @(negedge clk); n++; end
    check(n >= MEM - 2 && n <= MEM + 2, "R13", "init sweep cycles", n, MEM);
    // R1: deselected means not ready
    check(!rdy_a && !rdy_b, "R1", "ready while deselected", {rdy_a, rdy_b}, 0);

    for (int i = 0; i < NV; i++)
      xfer(VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
           $sformatf("R%0d", VEC[i][31:28]));

    // R6: 0xEB, six header bytes on A, eight on B
    xfer(1'b1, 8'hEB, 8'h00, 8'h00, "R6");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R6");
    xfer(1'b0, 8'h01, 8'h00, 8'h00, "R6");
    xfer(1'b0, 8'h11, 8'h00, 8'h00, "R6");
    for (int k = 0; k < 3; k++) xfer(1'b0, 8'h00, 8'h00, 8'h00, "R6");
    xfer(1'b0, 8'h00, 8'h0C, 8'h00, "R6");
    xfer(1'b0, 8'h00, 8'hFF, 8'h00, "R6");
    xfer(1'b0, 8'h00, 8'hFF, 8'h0F, "R6");

    // R7: address reduced modulo size, read wraps to zero
    xfer(1'b1, 8'h06, 8'h00, 8'h00, "R7");
    prog1(24'h000000, 8'h42, "R7");
    xfer(1'b1, 8'h03, 8'h00, 8'h00, "R7");
    xfer(1'b0, 8'h7F, 8'h00, 8'h00, "R7");
    xfer(1'b0, 8'hFF, 8'h00, 8'h00, "R7");
    xfer(1'b0, 8'hFF, 8'h00, 8'h00, "R7");
    xfer(1'b0, 8'h00, 8'hFF, 8'hFF, "R7");
    xfer(1'b0, 8'h00, 8'h42, 8'h42, "R7");

    // R12: unknown opcode mutes the rest of the selection (0x04 ignored)
    xfer(1'b1, 8'h77, 8'h00, 8'h00, "R12");
    xfer(1'b0, 8'h04, 8'h00, 8'h00, "R12");
    xfer(1'b0, 8'h05, 8'h00, 8'h00, "R12");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R12");
    xfer(1'b1, 8'h05, 8'h00, 8'h00, "R12");
    xfer(1'b0, 8'h00, 8'h02, 8'h02, "R12");

    // R11: write-status with latch set clears it; without latch it is dropped
    xfer(1'b1, 8'h01, 8'h00, 8'h00, "R11");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R11");
    xfer(1'b0, 8'h05, 8'h00, 8'h00, "R11");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R11");
    xfer(1'b1, 8'h01, 8'h00, 8'h00, "R11");
    xfer(1'b0, 8'h06, 8'h00, 8'h00, "R11");
    xfer(1'b0, 8'h05, 8'h00, 8'h00, "R11");
    xfer(1'b0, 8'h00, 8'h02, 8'h02, "R11");

    // R2: deselect mid-header, next byte is an opcode
    xfer(1'b1, 8'h03, 8'h00, 8'h00, "R2");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R2");
    xfer(1'b1, 8'h05, 8'h00, 8'h00, "R2");
    xfer(1'b0, 8'h00, 8'h02, 8'h02, "R2");

    // R9: small-granule erase from an unaligned address (range 0x80..0xBF)
    prog1(24'h000080, 8'h11, "R9");
    prog1(24'h0000C0, 8'h22, "R9");
    prog1(24'h00007F, 8'h33, "R9");
    xfer(1'b1, 8'h20, 8'h00, 8'h00, "R9");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R9");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R9");
    xfer(1'b0, 8'hA5, 8'h00, 8'h00, "R9");
    check(busy_a && !rdy_a, "R1", "stall during erase", {busy_a, rdy_a}, 2'b10);
    rd(24'h00007F, 8'h33, 8'h33, "R9");
    rd(24'h000080, 8'hFF, 8'hFF, "R9");
    rd(24'h0000C0, 8'h22, 8'h22, "R9");

    // R10: erases with latch clear do nothing
    xfer(1'b1, 8'h04, 8'h00, 8'h00, "R10");
    xfer(1'b1, 8'h20, 8'h00, 8'h00, "R10");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R10");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R10");
    xfer(1'b0, 8'hC0, 8'h00, 8'h00, "R10");
    check(!busy_a, "R10", "no sweep without latch", busy_a, 0);
    rd(24'h0000C0, 8'h22, 8'h22, "R10");
    xfer(1'b1, 8'hC7, 8'h00, 8'h00, "R10");
    check(!busy_a, "R10", "no chip sweep without latch", busy_a, 0);
    rd(24'h000000, 8'h42, 8'h42, "R10");

    // R9: medium granule from 0x1F0 clears 0x100..0x1FF only
    xfer(1'b1, 8'h06, 8'h00, 8'h00, "R9");
    xfer(1'b1, 8'h52, 8'h00, 8'h00, "R9");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R9");
    xfer(1'b0, 8'h01, 8'h00, 8'h00, "R9");
    xfer(1'b0, 8'hF0, 8'h00, 8'h00, "R9");
    rd(24'h000110, 8'hFF, 8'hFF, "R9");
    rd(24'h0000C0, 8'h22, 8'h22, "R9");
    // R9: sector from 0xC5 clears 0x80..0xFF
    xfer(1'b1, 8'hD8, 8'h00, 8'h00, "R9");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R9");
    xfer(1'b0, 8'h00, 8'h00, 8'h00, "R9");
    xfer(1'b0, 8'hC5, 8'h00, 8'h00, "R9");
    rd(24'h0000C0, 8'hFF, 8'hFF, "R9");
    rd(24'h00007F, 8'h33, 8'h33, "R9");
    // R9: whole array
    xfer(1'b1, 8'hC7, 8'h00, 8'h00, "R9");
    rd(24'h000000, 8'hFF, 8'hFF, "R9");
    rd(24'h00007F, 8'hFF, 8'hFF, "R9");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R1 watchdog: actual=hung expected=complete");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule